// File: doc/BRIEF.md
# SPI Command Frame Timeout Monitor

This block sits beside an SPI slave's serial front end and limits how long a complete command may take. The moment a command opens, on the first serial-clock rising edge seen after idle, it starts counting modulator-rate ticks. The command closes when the front end reports its final byte. The monitor decodes the first byte of every command to learn how long the command is. Register access commands carry one to four data bytes after the command byte, and every other command is a single byte. The limit covers the whole multi-byte command, not just the command byte.

If the limit runs out before the command closes, the monitor raises a one-cycle interface-reset pulse and drops back to idle. The next serial-clock rising edge then opens a fresh command. A command that closes in time produces a one-cycle completion pulse. The limit depends on the operating mode: one count for the normal and duty-cycle modes and twice that count for turbo mode. The modulator rate in turbo mode is also double, so the wall-clock window is the same in every mode. The serial clock is brought into the system clock domain through a flop synchronizer before its edges are detected.

Top module: `spi_cmd_timeout_mon`

## Requirements
- R1: While and right after synchronous reset, `if_reset` and `cmd_done` are low and the monitor is idle.
- R2: A command opens on the first rising edge of `sclk_in`, after a two-flop synchronizer, while idle. Ticks that arrive while idle are not counted. Further rising edges during an open command neither restart nor clear the count.
- R3: Only cycles with `mod_tick` high advance the count. The limit is `NORM_LIMIT` ticks when `turbo_sel` is 0 and `TURBO_LIMIT` ticks when it is 1.
- R4: A first byte with bits [7:6] equal to 2'b10 is a register command followed by bits[1:0]+1 data bytes. Any other first byte is a one-byte command. Data bytes are never decoded as commands.
- R5: When the final byte of an open command is strobed before the limit is reached, `cmd_done` is high for exactly the next cycle and the monitor returns to idle.
- R6: When the tick that brings the count to the limit arrives and the command is still open, `if_reset` is high for exactly the next cycle, once per command, and the monitor goes idle.
- R7: A final byte strobed in the same cycle as the tick that reaches the limit counts as completed: `cmd_done` pulses and `if_reset` does not.
- R8: `byte_valid` strobes while idle, including the bytes that follow a timeout, have no effect.
- R9: After a timeout, the next rising edge of `sclk_in` opens a new command, which can complete normally.
- R10: `if_reset` and `cmd_done` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_tick | input | 1 | One-cycle strobe at the modulator rate |
| sclk_in | input | 1 | Asynchronous serial clock from the SPI pin |
| byte_data | input | 8 | Byte delivered by the serial front end |
| byte_valid | input | 1 | Strobe marking `byte_data` valid (byte finished on a falling edge) |
| turbo_sel | input | 1 | 1 selects the turbo-mode limit |
| if_reset | output | 1 | One-cycle pulse that resets the serial interface |
| cmd_done | output | 1 | One-cycle pulse when a command finishes in time |

## Verification
Completion and expiry can land in the same cycle: the final byte strobe can arrive with the very tick that brings the count to the limit. The bench sweeps the number of ticks placed before the final byte from zero to past the limit. It sends the final byte together with one more tick, for every command length and both modes. It expects a completion pulse exactly when the ticks before the final byte number fewer than the limit, and an interface reset, at the precise tick, otherwise. Pulse counters confirm that the two outputs never both fire and that each fires at most once per command.

// File: rtl/spi_tmo_pkg.sv
package spi_tmo_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_OPEN = 1'b1} mon_state_t;
  localparam int PAY_W = 3;
  localparam logic [1:0] REG_TAG = 2'b10;
endpackage

// File: rtl/sclk_edge_sync.sv
module sclk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_async,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= sclk_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign rise = chain_q[STAGES-1] & ~prev_q;

  // R2
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/cmd_len_decode.sv
module cmd_len_decode
  import spi_tmo_pkg::*;
(
  input  logic [7:0]       cmd_byte,
  output logic             is_reg,
  output logic [PAY_W-1:0] pay_cnt
);
  always_comb begin
    is_reg  = (cmd_byte[7:6] == REG_TAG);
    pay_cnt = is_reg ? ({1'b0, cmd_byte[1:0]} + PAY_W'(1)) : '0;
  end
endmodule

// File: rtl/frame_timer.sv
module frame_timer #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             reach
);
  logic [CNT_W-1:0] count_q;

  assign reach = run && (count_q + CNT_W'(1) == limit);

  always_ff @(posedge clk) begin
    if (rst || clear)                 count_q <= '0;
    else if (run && count_q < limit)  count_q <= count_q + CNT_W'(1);
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count_q <= limit);
  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !clear) |=> $stable(count_q));
endmodule

// File: rtl/spi_cmd_timeout_mon.sv
module spi_cmd_timeout_mon
  import spi_tmo_pkg::*;
#(
  parameter int NORM_LIMIT  = 13955,
  parameter int TURBO_LIMIT = 27910,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mod_tick,
  input  logic       sclk_in,
  input  logic [7:0] byte_data,
  input  logic       byte_valid,
  input  logic       turbo_sel,
  output logic       if_reset,
  output logic       cmd_done
);
  localparam int MAX_LIMIT = (NORM_LIMIT > TURBO_LIMIT) ? NORM_LIMIT : TURBO_LIMIT;
  localparam int CNT_W     = $clog2(MAX_LIMIT + 1);

  mon_state_t       state_q;
  logic             first_q;
  logic [PAY_W-1:0] left_q;
  logic             sclk_rise;
  logic             dec_reg;
  logic [PAY_W-1:0] dec_cnt;
  logic             opened;
  logic             complete_evt;
  logic             reach;
  logic             timeout_evt;
  logic [CNT_W-1:0] limit_sel;

  sclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .sclk_async (sclk_in),
    .rise       (sclk_rise)
  );

  cmd_len_decode u_dec (
    .cmd_byte (byte_data),
    .is_reg   (dec_reg),
    .pay_cnt  (dec_cnt)
  );

  assign opened    = (state_q == ST_OPEN);
  assign limit_sel = turbo_sel ? CNT_W'(TURBO_LIMIT) : CNT_W'(NORM_LIMIT);

  always_comb begin
    complete_evt = 1'b0;
    if (opened && byte_valid) begin
      if (first_q) complete_evt = !dec_reg;
      else         complete_evt = (left_q == PAY_W'(1));
    end
  end

  assign timeout_evt = reach && !complete_evt;

  frame_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clear (!opened || complete_evt || timeout_evt),
    .run   (opened && mod_tick),
    .limit (limit_sel),
    .reach (reach)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      first_q  <= 1'b1;
      left_q   <= '0;
      if_reset <= 1'b0;
      cmd_done <= 1'b0;
    end else begin
      if_reset <= timeout_evt;
      cmd_done <= complete_evt;
      if (!opened) begin
        if (sclk_rise) begin
          state_q <= ST_OPEN;
          first_q <= 1'b1;
          left_q  <= '0;
        end
      end else if (complete_evt || timeout_evt) begin
        state_q <= ST_IDLE;
        first_q <= 1'b1;
        left_q  <= '0;
      end else if (byte_valid) begin
        if (first_q) begin
          first_q <= 1'b0;
          left_q  <= dec_cnt;
        end else begin
          left_q  <= left_q - PAY_W'(1);
        end
      end
    end
  end

  // R10
  excl_out_chk: assert property (@(posedge clk) disable iff (rst)
    !(if_reset && cmd_done));
  // R6
  reset_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    if_reset |-> (state_q == ST_IDLE) && !$past(if_reset));
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_done |-> (state_q == ST_IDLE) && !$past(cmd_done));
  // R2
  open_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!opened && sclk_rise) |=> (state_q == ST_OPEN));
  // R4
  payload_range_chk: assert property (@(posedge clk) disable iff (rst)
    left_q <= PAY_W'(4));
endmodule

// File: tb/spi_cmd_timeout_mon_tb.sv
`timescale 1ns/100ps
module spi_cmd_timeout_mon_tb;
  localparam int NL = 6;
  localparam int TL = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mod_tick = 1'b0;
  logic sclk_in = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic byte_valid = 1'b0;
  logic turbo_sel = 1'b0;
  logic if_reset;
  logic cmd_done;

  int n_chk = 0;
  int n_fail = 0;
  int rst_pulses = 0;
  int done_pulses = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  spi_cmd_timeout_mon #(.NORM_LIMIT(NL), .TURBO_LIMIT(TL), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .mod_tick(mod_tick), .sclk_in(sclk_in),
    .byte_data(byte_data), .byte_valid(byte_valid), .turbo_sel(turbo_sel),
    .if_reset(if_reset), .cmd_done(cmd_done)
  );

  always @(negedge clk) begin
    if (if_reset) rst_pulses++;
    if (cmd_done) done_pulses++;
    if (!rst && if_reset && cmd_done) begin
      n_fail++;
      $display("FAIL R10: if_reset=%0b cmd_done=%0b expected not both", if_reset, cmd_done);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic open_frame();
    sclk_in = 1'b1;
    repeat (3) step();
  endtask

  task automatic toggle_sclk();
    sclk_in = 1'b0; repeat (3) step();
    sclk_in = 1'b1; repeat (3) step();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit with_tick);
    byte_data = b; byte_valid = 1'b1; mod_tick = with_tick;
    step();
    byte_valid = 1'b0; mod_tick = 1'b0;
    step();
  endtask

  // One command: nb bytes, t ticks before the final byte, final byte carries a tick.
  task automatic run_case(input bit turbo, input logic [7:0] cmd, input int nb, input int t);
    int lim;
    bit exp_tmo;
    lim = turbo ? TL : NL;
    exp_tmo = (t >= lim);
    turbo_sel = turbo;
    rst_pulses = 0; done_pulses = 0;
    open_frame();
    for (int b = 0; b < nb - 1; b++) begin
      byte_data = (b == 0) ? cmd : 8'h80; byte_valid = 1'b1;
      step();
      byte_valid = 1'b0;
      toggle_sclk();
    end
    for (int i = 1; i <= t; i++) begin
      mod_tick = 1'b1; step(); mod_tick = 1'b0;
      // R6: pulse in the cycle after the tick that reaches the limit (R3 limit per mode)
      check(if_reset == (i == lim), (i == lim) ? "R6" : "R3", int'(if_reset), int'(i == lim));
      step();
    end
    byte_data = (nb == 1) ? cmd : 8'h80; byte_valid = 1'b1; mod_tick = 1'b1;
    step();
    byte_valid = 1'b0; mod_tick = 1'b0;
    // R7 when t+1 == lim; R5 otherwise; R8 when already timed out
    check(cmd_done == !exp_tmo, (t + 1 == lim) ? "R7" : (exp_tmo ? "R8" : "R5"),
          int'(cmd_done), int'(!exp_tmo));
    sclk_in = 1'b0;
    repeat (4) step();
    check(rst_pulses == int'(exp_tmo), "R6", rst_pulses, int'(exp_tmo));
    check(done_pulses == int'(!exp_tmo), (nb > 1) ? "R4" : "R5", done_pulses, int'(!exp_tmo));
  endtask

  initial begin
    repeat (3) step();
    // R1
    check(if_reset == 1'b0, "R1", int'(if_reset), 0);
    check(cmd_done == 1'b0, "R1", int'(cmd_done), 0);
    rst = 1'b0;
    repeat (2) step();
    check(if_reset == 1'b0 && cmd_done == 1'b0, "R1", int'(if_reset) + int'(cmd_done), 0);

    // R8: byte strobes while idle do nothing
    done_pulses = 0;
    send_byte(8'h3C, 1'b0);
    repeat (2) step();
    check(done_pulses == 0, "R8", done_pulses, 0);

    // R2: ticks in idle are not counted
    rst_pulses = 0;
    for (int i = 0; i < TL + 3; i++) begin
      mod_tick = 1'b1; step(); mod_tick = 1'b0; step();
    end
    check(rst_pulses == 0, "R2", rst_pulses, 0);
    // R2: command opened afterwards still has the full window
    run_case(1'b0, 8'h3C, 1, NL - 1);

    // R2: rising edges inside a command do not restart the count
    rst_pulses = 0;
    turbo_sel = 1'b0;
    open_frame();
    for (int i = 0; i < NL - 1; i++) begin
      mod_tick = 1'b1; step(); mod_tick = 1'b0;
      toggle_sclk();
    end
    check(rst_pulses == 0, "R2", rst_pulses, 0);
    mod_tick = 1'b1; step(); mod_tick = 1'b0;
    check(if_reset == 1'b1, "R2", int'(if_reset), 1);
    sclk_in = 1'b0; repeat (4) step();

    // R9: after a timeout the next rising edge starts a fresh command
    run_case(1'b0, 8'h3C, 1, 0);

    // Sweep: both modes, one-byte commands and register commands of 1..4 data bytes
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 6; c++) begin
        for (int t = 0; t <= (m ? TL : NL) + 1; t++) begin
          logic [7:0] cmd;
          int nb;
          case (c)
            0: begin cmd = 8'h3C; nb = 1; end
            1: begin cmd = 8'hC3; nb = 1; end
            default: begin cmd = 8'hA4 | 8'(c - 2); nb = c; end
          endcase
          run_case(m[0], cmd, nb, t);
        end
      end
    end
    // R9: command after a timed-out register command completes
    run_case(1'b1, 8'hA7, 5, TL + 1);
    run_case(1'b1, 8'hA7, 5, 2);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule